// File: doc/BRIEF.md
# Locked Read-Modify-Write Bus Sequencer

This block sits between a processor core and a single memory port and carries out atomic read-modify-write sequences. A request marked as locked read opens a locked sequence. The block asserts a lock output toward memory, performs the read and then holds the bus. Only the matching locked write to the same address closes the sequence. While the bus is held, every other request from the core is stalled at the request handshake. Stalled requests are kept waiting and are never dropped.

A held lock whose write never arrives would block the bus for good. Exception logic can cancel the sequence through an abort input, and the block then releases the lock without writing anything. This lets an intervening fault, and the memory traffic that handling it needs, proceed, and the faulting instruction can be restarted. Requests that the core has already flagged as invalid never reach the bus. A watchdog counts the cycles spent holding the lock and raises a one-cycle timeout indication when a configurable limit is reached.

Top module: `lkseq_top`

## Requirements
- R1: An unlocked read or write (`req_lock`=0) performs exactly one memory cycle with `mem_lock` low. `rsp_valid` rises the cycle after `mem_ready` is seen, with `rsp_err`=0 and, for a read, the data read.
- R2: A locked read (`req_lock`=1, `req_write`=0) drives a read with `mem_lock` high. When it completes, the block answers with the data and `rsp_err`=0, then holds: `mem_lock` stays high and `mem_valid` stays low.
- R3: While holding, `req_ready` is high only for a locked write (`req_lock`=1, `req_write`=1, `req_invalid`=0) to the held address. Every other request sees `req_ready` low, stays pending, and no memory cycle starts.
- R4: The accepted locked write is issued with `mem_lock` high. The cycle after it completes, `mem_lock` is low, `rsp_valid`=1 and `rsp_err`=0.
- R5: A locked write presented while no sequence is open is carried out as a plain write with `mem_lock` low.
- R6: A request with `req_invalid`=1 is accepted but starts no memory cycle and never raises `mem_lock`. The next cycle it is answered with `rsp_err`=1.
- R7: `abort_in` high during holding releases the lock: the next cycle `mem_lock` and `mem_valid` are low and an `rsp_err`=1 response is given. No write is issued, and `req_ready` returns one cycle later.
- R8: `abort_in` seen at any point while the locked read is still waiting for `mem_ready` lets the read finish. The block then releases the lock without holding and answers with `rsp_err`=1 and the read data.
- R9: `abort_in` while the locked write is in progress has no effect: the write completes and is answered with `rsp_err`=0.
- R10: `timeout_err` is high for exactly one cycle, the LIMIT-th consecutive cycle of holding. It does not release the lock.
- R11: After reset, `req_ready` is high and `mem_valid`, `mem_lock`, `rsp_valid` and `timeout_err` are low.
- R12: While `mem_valid` is high and `mem_ready` low, `mem_valid`, `mem_addr`, `mem_write` and `mem_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lock | input | 1 | Request belongs to a locked sequence |
| req_invalid | input | 1 | Instruction already flagged invalid by decode |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Response reports a cancelled or invalid request |
| rsp_rdata | output | DATA_W | Read data of the response |
| mem_valid | output | 1 | Memory cycle requested |
| mem_ready | input | 1 | Memory accepts the cycle |
| mem_write | output | 1 | Memory cycle is a write |
| mem_lock | output | 1 | Bus lock toward memory |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| abort_in | input | 1 | Exception cancels an open locked sequence |
| timeout_err | output | 1 | Lock held for LIMIT cycles |

## Verification
Some properties are checked on every cycle. These cover the stability of a pending memory cycle, the release of the lock after the locked write and after an abort in holding, the absence of bus activity after an invalid request, and the restriction on what may be accepted while holding. The timeout pulse is also checked to appear only while holding. Other behaviour only the scenarios can show: that a request stalled during holding is served intact after the abort, that an aborted sequence left memory untouched, that a late abort during the read suppresses holding, and that the timeout comes exactly once at the LIMIT-th cycle.

// File: rtl/lkseq_pkg.sv
package lkseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAIN,
        ST_LOCK_RD,
        ST_HOLD,
        ST_LOCK_WR,
        ST_ABORT
    } seq_state_e;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_OK,
        RK_ERR
    } rsp_kind_e;

    typedef enum logic [1:0] {
        RC_PLAIN,
        RC_LOCK_RD,
        RC_INVALID
    } req_class_e;

    // Invalid requests never open a locked sequence; a lone locked write is plain.
    function automatic req_class_e classify(input logic wr, input logic lk, input logic inv);
        if (inv)
            return RC_INVALID;
        else if (lk && !wr)
            return RC_LOCK_RD;
        else
            return RC_PLAIN;
    endfunction

    function automatic logic drives_bus(input seq_state_e s);
        return (s == ST_PLAIN) || (s == ST_LOCK_RD) || (s == ST_LOCK_WR);
    endfunction

    function automatic logic holds_lock(input seq_state_e s);
        return (s == ST_LOCK_RD) || (s == ST_HOLD) || (s == ST_LOCK_WR);
    endfunction

endpackage

// File: rtl/lkseq_cmd.sv
module lkseq_cmd #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    output logic              addr_match
);
    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } cmd_t;

    cmd_t cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (load) begin
            cmd_q.write <= req_write;
            cmd_q.addr  <= req_addr;
            cmd_q.wdata <= req_wdata;
        end
    end

    assign cmd_write  = cmd_q.write;
    assign cmd_addr   = cmd_q.addr;
    assign cmd_wdata  = cmd_q.wdata;
    assign addr_match = (req_addr == cmd_q.addr);
endmodule

// File: rtl/lkseq_fsm.sv
module lkseq_fsm
    import lkseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       req_lock,
    input  logic       req_invalid,
    input  logic       addr_match,
    input  logic       abort_in,
    input  logic       mem_ready,
    output seq_state_e state,
    output logic       req_ready,
    output logic       cmd_load,
    output rsp_kind_e  rsp_kind
);
    seq_state_e state_d;
    logic       abort_pend;
    logic       abort_pend_d;
    logic       accept;
    logic       pair_ok;
    req_class_e cls;

    assign cls     = classify(req_write, req_lock, req_invalid);
    assign pair_ok = req_lock && req_write && !req_invalid && addr_match && !abort_in;

    always_comb begin
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_HOLD: req_ready = pair_ok;
            default: req_ready = 1'b0;
        endcase
    end

    assign accept = req_valid && req_ready;

    always_comb begin
        state_d      = state;
        cmd_load     = 1'b0;
        rsp_kind     = RK_NONE;
        abort_pend_d = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    unique case (cls)
                        RC_INVALID: rsp_kind = RK_ERR;
                        RC_LOCK_RD: begin
                            cmd_load = 1'b1;
                            state_d  = ST_LOCK_RD;
                        end
                        default: begin
                            cmd_load = 1'b1;
                            state_d  = ST_PLAIN;
                        end
                    endcase
                end
            end
            ST_PLAIN: begin
                if (mem_ready) begin
                    rsp_kind = RK_OK;
                    state_d  = ST_IDLE;
                end
            end
            ST_LOCK_RD: begin
                abort_pend_d = abort_pend || abort_in;
                if (mem_ready) begin
                    abort_pend_d = 1'b0;
                    if (abort_pend || abort_in) begin
                        rsp_kind = RK_ERR;
                        state_d  = ST_ABORT;
                    end else begin
                        rsp_kind = RK_OK;
                        state_d  = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (abort_in) begin
                    rsp_kind = RK_ERR;
                    state_d  = ST_ABORT;
                end else if (accept) begin
                    cmd_load = 1'b1;
                    state_d  = ST_LOCK_WR;
                end
            end
            ST_LOCK_WR: begin
                if (mem_ready) begin
                    rsp_kind = RK_OK;
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            abort_pend <= 1'b0;
        end else begin
            state      <= state_d;
            abort_pend <= abort_pend_d;
        end
    end

    // R8: an abort during the locked read never leads back to a plain idle without release
    p_lockrd_abort_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCK_RD && abort_in) |=> (state == ST_LOCK_RD || state == ST_ABORT));

    // R9: the locked write is not cut short by an abort
    p_wr_no_abort_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCK_WR && !mem_ready) |=> (state == ST_LOCK_WR));
endmodule

// File: rtl/lkseq_wdog.sv
module lkseq_wdog #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic in_hold,
    output logic timeout
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !in_hold)
            cnt <= '0;
        else if (cnt != CW'(LIMIT))
            cnt <= cnt + 1'b1;
    end

    assign timeout = in_hold && (cnt == CW'(LIMIT - 1));

    // R10: the hold counter saturates and never wraps into a second pulse
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(LIMIT));
endmodule

// File: rtl/lkseq_rsp.sv
module lkseq_rsp
    import lkseq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  rsp_kind_e         rsp_kind,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (rsp_kind != RK_NONE);
            rsp_err   <= (rsp_kind == RK_ERR);
            if (cap_en)
                rsp_rdata <= mem_rdata;
        end
    end
endmodule

// File: rtl/lkseq_top.sv
module lkseq_top
    import lkseq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LIMIT  = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_lock,
    input  logic              req_invalid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              abort_in,
    output logic              timeout_err
);
    seq_state_e state;
    rsp_kind_e  rsp_kind;
    logic       cmd_load;
    logic       addr_match;
    logic       cmd_write;

    lkseq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_lock    (req_lock),
        .req_invalid (req_invalid),
        .addr_match  (addr_match),
        .abort_in    (abort_in),
        .mem_ready   (mem_ready),
        .state       (state),
        .req_ready   (req_ready),
        .cmd_load    (cmd_load),
        .rsp_kind    (rsp_kind)
    );

    lkseq_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .load       (cmd_load),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .cmd_write  (cmd_write),
        .cmd_addr   (mem_addr),
        .cmd_wdata  (mem_wdata),
        .addr_match (addr_match)
    );

    lkseq_wdog #(.LIMIT(LIMIT)) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .in_hold (state == ST_HOLD),
        .timeout (timeout_err)
    );

    lkseq_rsp #(.DATA_W(DATA_W)) u_rsp (
        .clk       (clk),
        .rst       (rst),
        .rsp_kind  (rsp_kind),
        .cap_en    (mem_valid && mem_ready && !mem_write),
        .mem_rdata (mem_rdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_valid = drives_bus(state);
    assign mem_lock  = holds_lock(state);
    assign mem_write = cmd_write;

    // R12: a pending memory cycle does not change under a stall
    p_mem_stable_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_write) && $stable(mem_wdata)));

    // R4: completing the locked write drops the lock and answers
    p_unlock_after_wr_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write && mem_lock && mem_ready)
            |=> (!mem_lock && rsp_valid && !rsp_err));

    // R7: abort while holding releases the lock without a bus cycle
    p_abort_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_lock && !mem_valid && abort_in)
            |=> (!mem_lock && !mem_valid && rsp_valid && rsp_err));

    // R6: an invalid request touches no bus and is answered with an error
    p_invalid_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_invalid)
            |=> (!mem_valid && !mem_lock && rsp_valid && rsp_err));

    // R3: while holding only a locked write may be accepted
    p_hold_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_lock && !mem_valid && req_valid && req_ready) |-> (req_lock && req_write));

    // R10: the timeout pulse only appears while holding
    p_timeout_r10: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> (mem_lock && !mem_valid));
endmodule

// File: tb/lkseq_top_bench.sv
module lkseq_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 4;
    localparam int DW    = 16;
    localparam int LIM   = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0, req_lock = 1'b0, req_invalid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic          mem_valid, mem_ready, mem_write, mem_lock;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          abort_in = 1'b0;
    logic          timeout_err;
    logic          mstall = 1'b0;

    logic [DW-1:0] mem_arr [DEPTH];
    logic [DW-1:0] ref_mem [DEPTH];

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lkseq_top #(.ADDR_W(AW), .DATA_W(DW), .LIMIT(LIM)) u_lkseq_top (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_lock(req_lock), .req_invalid(req_invalid), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_write(mem_write), .mem_lock(mem_lock), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .abort_in(abort_in),
        .timeout_err(timeout_err)
    );

    // memory model
    assign mem_ready = mem_valid && !mstall;
    assign mem_rdata = mem_arr[mem_addr];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_arr[i] = DW'(i * 37 + 5);
            ref_mem[i] = DW'(i * 37 + 5);
        end
    end

    always @(posedge clk)
        if (mem_valid && mem_ready && mem_write)
            mem_arr[mem_addr] <= mem_wdata;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard
    typedef struct {
        logic          err;
        logic          chk_data;
        logic [DW-1:0] data;
        string         req;
    } exp_t;
    exp_t exp_q[$];

    task automatic expect_rsp(input logic err, input logic chk, input logic [DW-1:0] d,
                              input string req);
        exp_t e;
        e.err = err; e.chk_data = chk; e.data = d; e.req = req;
        exp_q.push_back(e);
    endtask

    // trackers sampled away from the active edge
    int hold_run = 0, tcount = 0, tidx = 0;
    int lock_cycles = 0, bus_cycles = 0, locked_writes = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1", "unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rsp_err == e.err, e.req, "rsp_err", rsp_err, e.err);
                    if (e.chk_data)
                        check(rsp_rdata == e.data, e.req, "rsp_rdata", rsp_rdata, e.data);
                end
            end
            if (mem_lock && !mem_valid) hold_run++;
            else hold_run = 0;
            if (timeout_err) begin
                tcount++;
                tidx = hold_run;
            end
            if (mem_lock) lock_cycles++;
            if (mem_valid) bus_cycles++;
            if (mem_valid && mem_ready && mem_write && mem_lock) locked_writes++;
        end
    end

    task automatic send(input logic wr, input logic lk, input logic inv,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_write = wr; req_lock = lk; req_invalid = inv; req_addr = a; req_wdata = d;
        req_valid = 1'b1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(exp_q.size() == 0, "R1", "response missing", exp_q.size(), 0);
        @(negedge clk);
    endtask

    task automatic plain_read(input logic [AW-1:0] a, input string req);
        expect_rsp(1'b0, 1'b1, ref_mem[a], req);
        send(1'b0, 1'b0, 1'b0, a, '0);
        drain();
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int lc, bc, lw;
        logic ok_flag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        check(req_ready && !mem_valid && !mem_lock && !rsp_valid && !timeout_err,
              "R11", "reset outputs", {req_ready, mem_valid, mem_lock, rsp_valid, timeout_err},
              5'b10000);

        // R1 plain write then read, lock never raised
        lc = lock_cycles;
        expect_rsp(1'b0, 1'b0, '0, "R1");
        send(1'b1, 1'b0, 1'b0, 4'd3, 16'hA5C3);
        ref_mem[3] = 16'hA5C3;
        drain();
        plain_read(4'd3, "R1");
        plain_read(4'd6, "R1");
        check(lock_cycles == lc, "R1", "lock during plain access", lock_cycles, lc);

        // R12 stalled plain read returns correct data
        mstall = 1'b1;
        expect_rsp(1'b0, 1'b1, ref_mem[8], "R12");
        send(1'b0, 1'b0, 1'b0, 4'd8, '0);
        repeat (3) @(negedge clk);
        #1;
        check(mem_valid && mem_addr == 4'd8 && !mem_write, "R12", "pending cycle",
              {mem_valid, mem_addr}, {1'b1, 4'd8});
        mstall = 1'b0;
        drain();

        // R2 / R4 locked pair
        expect_rsp(1'b0, 1'b1, ref_mem[5], "R2");
        send(1'b0, 1'b1, 1'b0, 4'd5, '0);
        drain();
        #1;
        check(mem_lock && !mem_valid, "R2", "holding after locked read",
              {mem_lock, mem_valid}, 2'b10);
        lw = locked_writes;
        expect_rsp(1'b0, 1'b0, '0, "R4");
        send(1'b1, 1'b1, 1'b0, 4'd5, 16'h1234);
        ref_mem[5] = 16'h1234;
        drain();
        #1;
        check(!mem_lock, "R4", "lock after write", mem_lock, 0);
        check(locked_writes == lw + 1, "R4", "locked write issued", locked_writes, lw + 1);
        plain_read(4'd5, "R4");

        // R5 lone locked write is plain
        lc = lock_cycles;
        expect_rsp(1'b0, 1'b0, '0, "R5");
        send(1'b1, 1'b1, 1'b0, 4'd7, 16'h0F0F);
        ref_mem[7] = 16'h0F0F;
        drain();
        check(lock_cycles == lc, "R5", "lock on lone locked write", lock_cycles, lc);
        plain_read(4'd7, "R5");

        // R6 invalid request
        lc = lock_cycles;
        bc = bus_cycles;
        expect_rsp(1'b1, 1'b0, '0, "R6");
        send(1'b0, 1'b1, 1'b1, 4'd2, '0);
        drain();
        repeat (2) @(negedge clk);
        check(lock_cycles == lc && bus_cycles == bc, "R6", "bus activity after invalid",
              bus_cycles - bc, 0);

        // R3 / R10 / R7 stalled requests while holding, then abort
        expect_rsp(1'b0, 1'b1, ref_mem[9], "R2");
        send(1'b0, 1'b1, 1'b0, 4'd9, '0);
        drain();
        lw = locked_writes;
        @(negedge clk);
        req_write = 1'b0; req_lock = 1'b0; req_invalid = 1'b0; req_addr = 4'd2;
        req_valid = 1'b1;
        ok_flag = 1'b1;
        for (int i = 0; i < 6; i++) begin
            #1;
            if (req_ready || mem_valid || !mem_lock) ok_flag = 1'b0;
            @(negedge clk);
        end
        check(ok_flag, "R3", "plain request stalled while holding", ok_flag, 1);
        req_write = 1'b1; req_lock = 1'b1; req_addr = 4'd10; req_wdata = 16'hDEAD;
        ok_flag = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1;
            if (req_ready || mem_valid) ok_flag = 1'b0;
            @(negedge clk);
        end
        check(ok_flag, "R3", "wrong-address locked write stalled", ok_flag, 1);
        req_write = 1'b0; req_lock = 1'b0; req_addr = 4'd2;
        #1;
        check(tcount == 1 && tidx == LIM, "R10", "timeout position", tidx, LIM);
        check(tcount == 1, "R10", "timeout pulse count", tcount, 1);
        check(mem_lock, "R10", "lock kept after timeout", mem_lock, 1);
        expect_rsp(1'b1, 1'b0, '0, "R7");
        expect_rsp(1'b0, 1'b1, ref_mem[2], "R3");
        @(negedge clk);
        abort_in = 1'b1;
        @(negedge clk);
        abort_in = 1'b0;
        #1;
        check(!mem_lock && !mem_valid && !req_ready, "R7", "release after abort",
              {mem_lock, mem_valid, req_ready}, 3'b000);
        @(negedge clk);
        #1;
        check(req_ready, "R7", "ready one cycle after abort", req_ready, 1);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        drain();
        check(locked_writes == lw, "R7", "write issued after abort", locked_writes, lw);
        plain_read(4'd9, "R7");

        // R8 abort during a stalled locked read
        mstall = 1'b1;
        expect_rsp(1'b1, 1'b1, ref_mem[11], "R8");
        send(1'b0, 1'b1, 1'b0, 4'd11, '0);
        @(negedge clk);
        abort_in = 1'b1;
        @(negedge clk);
        abort_in = 1'b0;
        @(negedge clk);
        mstall = 1'b0;
        drain();
        #1;
        check(!mem_lock && hold_run == 0, "R8", "no holding after late abort",
              mem_lock, 0);

        // R9 abort during the locked write has no effect
        expect_rsp(1'b0, 1'b1, ref_mem[12], "R9");
        send(1'b0, 1'b1, 1'b0, 4'd12, '0);
        drain();
        mstall = 1'b1;
        expect_rsp(1'b0, 1'b0, '0, "R9");
        send(1'b1, 1'b1, 1'b0, 4'd12, 16'hBEEF);
        @(negedge clk);
        abort_in = 1'b1;
        @(negedge clk);
        abort_in = 1'b0;
        mstall = 1'b0;
        ref_mem[12] = 16'hBEEF;
        drain();
        plain_read(4'd12, "R9");

        finish_run();
    end
endmodule